// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked system bus and an asynchronous static RAM that has an 18-bit address, a 16-bit data path and two byte lanes. It turns single-word read and write requests into strobe sequences whose phase lengths satisfy the memory's minimum timings. The host offers a request with a valid/ready handshake. Each request carries an address, write data, a two-bit byte enable and a read/write flag. Read data comes back with a one-clock response pulse.

Every strobe phase is counted in clock cycles. Each count is derived at elaboration from a nanosecond minimum for the chosen speed grade and the clock period. The byte-lane strobes follow the byte enables on their own. Every access ends in a bus-release phase. During that phase the chip is deselected, output enable is high and the controller does not drive the data bus. This means the memory's output buffers and the controller's drivers are never active together.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and while idle, chip select, output enable, write enable and both byte strobes are high (inactive), the data drive enable is low and `req_ready_o` is high.
- R2: Phase lengths in clock cycles are ceil(ns / CLK_NS) with a floor of 1. The read phase is the larger of the read-cycle and output-enable counts. The write phase is the largest of the write-cycle, write-pulse, select-to-end, address-to-end and data-setup counts. The release phase uses the output-float time. With the defaults (20 ns clock, fastest grade) these are 3, 3 and 2 cycles.
- R3: A read holds chip select and output enable low and write enable high for the whole read phase, starting on the clock edge that accepts the request.
- R4: During an access, the lower strobe (`sram_lb_n_o`, data bits 7:0) is low exactly when byte enable bit 0 is set, and the upper strobe (`sram_ub_n_o`, bits 15:8) is low exactly when bit 1 is set. A byte that is not enabled is returned as zero in the read data.
- R5: A write holds chip select and write enable low and output enable high for the whole write phase. For that whole phase the controller drives the registered write data with the drive enable high.
- R6: Every access is followed by the release phase with chip select, output enable and write enable high and the drive enable low. The write ends with write enable, chip select and the drive enable all changing on the same edge. The drive enable is never high while output enable is low.
- R7: Read data is sampled on the edge that ends the last read-phase cycle. `rsp_valid_o` is high for exactly one clock, in the first release cycle, and a write produces no response pulse.
- R8: A request is taken only while `req_ready_o` is high, which holds only in idle. Requests offered during an access or the release phase are ignored. The address, byte enables and write data stay constant on the memory pins for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle, request will be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address |
| req_be_i | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-clock pulse when read data is ready |
| rsp_rdata_o | output | 16 | Read data, disabled bytes zero |
| sram_addr_o | output | 18 | Memory address |
| sram_cs_n_o | output | 1 | Chip select, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_lb_n_o | output | 1 | Lower byte strobe, active low |
| sram_ub_n_o | output | 1 | Upper byte strobe, active low |
| sram_dq_o | output | 16 | Data toward the memory |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | 16 | Data from the memory |

## Verification
On every cycle, the assertions check the following: strobes are inactive whenever the chip is deselected, write enable and output enable are never low together, the controller never drives while output enable is low, a low write enable always comes with drive, the address holds still through an access, the response lasts one clock, and a release phase separates each access from the next acceptance. The bench's cycle-by-cycle scenarios are needed for the rest. These are the exact phase lengths, the lane strobes for each byte-enable pattern, partial writes merging into stored words, the masking of disabled read bytes, and requests offered while busy being dropped.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_TURN  = 2'd3
  } phase_e;

  // Clock cycles needed to cover ns, never less than one.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)              cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_d_o,
  output logic [BE_W-1:0]   be_d_o,
  output logic [DATA_W-1:0] wdata_d_o,
  output logic [BE_W-1:0]   be_q_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;

  assign addr_d_o  = load_i ? addr_i  : addr_q;
  assign be_d_o    = load_i ? be_i    : be_q;
  assign wdata_d_o = load_i ? wdata_i : wdata_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d_o;
      be_q    <= be_d_o;
      wdata_q <= wdata_d_o;
    end
  end

  assign be_q_o = be_q;
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [BE_W-1:0]   lane_n_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic active;
  assign active = rd_i | wr_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      addr_o  <= '0;
      cs_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      addr_o  <= addr_i;
      cs_n_o  <= ~active;
      oe_n_o  <= ~rd_i;
      we_n_o  <= ~wr_i;
      dq_o    <= wdata_i;
      dq_oe_o <= wr_i;
    end
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (rst_i) lane_n_o[g] <= 1'b1;
      else       lane_n_o[g] <= ~(active & be_i[g]);
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 20,
  parameter int T_RC_NS = 55,
  parameter int T_OE_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 40,
  parameter int T_CW_NS = 45,
  parameter int T_AW_NS = 45,
  parameter int T_DW_NS = 25,
  parameter int T_HZ_NS = 25
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_n_o,
  output logic              sram_oe_n_o,
  output logic              sram_we_n_o,
  output logic              sram_lb_n_o,
  output logic              sram_ub_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int BE_W   = DATA_W / 8;
  localparam int RD_CYC = max2(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS));
  localparam int WR_CYC = max2(max2(ns2cyc(T_WC_NS, CLK_NS), ns2cyc(T_WP_NS, CLK_NS)),
                               max2(max2(ns2cyc(T_CW_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                    ns2cyc(T_DW_NS, CLK_NS)));
  localparam int TA_CYC = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_C  = max2(max2(RD_CYC, WR_CYC), TA_CYC);
  localparam int CNT_W  = $clog2(MAX_C + 1);

  phase_e           ph_q, ph_d;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;
  logic             accept;

  logic [ADDR_W-1:0] addr_d;
  logic [BE_W-1:0]   be_d, be_q;
  logic [DATA_W-1:0] wdata_d;
  logic [BE_W-1:0]   lane_n;

  assign req_ready_o = (ph_q == PH_IDLE);
  assign accept      = req_ready_o & req_valid_i;

  always_comb begin
    ph_d   = ph_q;
    t_load = 1'b0;
    t_val  = '0;
    unique case (ph_q)
      PH_IDLE: if (req_valid_i) begin
        ph_d   = req_write_i ? PH_WRITE : PH_READ;
        t_load = 1'b1;
        t_val  = req_write_i ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
      end
      PH_READ, PH_WRITE: if (t_zero) begin
        ph_d   = PH_TURN;
        t_load = 1'b1;
        t_val  = CNT_W'(TA_CYC - 1);
      end
      PH_TURN: if (t_zero) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) ph_q <= PH_IDLE;
    else       ph_q <= ph_d;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (t_load),
    .load_val_i (t_val),
    .zero_o     (t_zero)
  );

  sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (accept),
    .addr_i    (req_addr_i),
    .be_i      (req_be_i),
    .wdata_i   (req_wdata_i),
    .addr_d_o  (addr_d),
    .be_d_o    (be_d),
    .wdata_d_o (wdata_d),
    .be_q_o    (be_q)
  );

  sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rd_i     (ph_d == PH_READ),
    .wr_i     (ph_d == PH_WRITE),
    .addr_i   (addr_d),
    .be_i     (be_d),
    .wdata_i  (wdata_d),
    .addr_o   (sram_addr_o),
    .cs_n_o   (sram_cs_n_o),
    .oe_n_o   (sram_oe_n_o),
    .we_n_o   (sram_we_n_o),
    .lane_n_o (lane_n),
    .dq_o     (sram_dq_o),
    .dq_oe_o  (sram_dq_oe_o)
  );

  assign sram_lb_n_o = lane_n[0];
  assign sram_ub_n_o = lane_n[1];

  // Capture on the edge closing the final read cycle.
  logic capture;
  assign capture = (ph_q == PH_READ) & t_zero;

  always_ff @(posedge clk_i) begin
    if (rst_i) rsp_valid_o <= 1'b0;
    else       rsp_valid_o <= capture;
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_cap
    always_ff @(posedge clk_i) begin
      if (rst_i)        rsp_rdata_o[8*g +: 8] <= '0;
      else if (capture) rsp_rdata_o[8*g +: 8] <= be_q[g] ? sram_dq_i[8*g +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sram_ctrl_sva.sv
module sram_ctrl_sva #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_cs_n_o,
  input logic              sram_oe_n_o,
  input logic              sram_we_n_o,
  input logic              sram_lb_n_o,
  input logic              sram_ub_n_o,
  input logic              sram_dq_oe_o
);
  p_deselect_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    sram_cs_n_o |-> (sram_oe_n_o && sram_we_n_o && sram_lb_n_o && sram_ub_n_o && !sram_dq_oe_o));

  p_no_oe_we_overlap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !(!sram_oe_n_o && !sram_we_n_o));

  p_write_drives_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !sram_we_n_o |-> sram_dq_oe_o);

  p_no_contention_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(sram_dq_oe_o && !sram_oe_n_o));

  p_release_gap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !sram_cs_n_o |=> (!sram_cs_n_o || !req_ready_o));

  p_rsp_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    rsp_valid_o |=> !rsp_valid_o);

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !sram_cs_n_o |=> (sram_cs_n_o || $stable(sram_addr_o)));

  p_busy_not_ready_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !sram_cs_n_o |-> !req_ready_o);
endmodule

bind sram_ctrl sram_ctrl_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_cs_n_o  (sram_cs_n_o),
  .sram_oe_n_o  (sram_oe_n_o),
  .sram_we_n_o  (sram_we_n_o),
  .sram_lb_n_o  (sram_lb_n_o),
  .sram_ub_n_o  (sram_ub_n_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;
  // Expected phase lengths from R2 at a 20 ns clock, fastest grade.
  localparam int CLK = 20;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int N_RD = (cyc(55) > cyc(25)) ? cyc(55) : cyc(25);
  localparam int N_WR = cyc(55);   // 55, 40, 45, 45, 25 ns -> largest is 3
  localparam int N_TA = cyc(25);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] s_addr;
  logic        s_cs_n, s_oe_n, s_we_n, s_lb_n, s_ub_n, s_doe;
  logic [15:0] s_dq_o;
  logic [15:0] s_dq_i = 16'h5A5A;

  sram_ctrl u_sram_ctrl (
    .clk_i(clk), .rst_i(rst),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(s_addr), .sram_cs_n_o(s_cs_n), .sram_oe_n_o(s_oe_n),
    .sram_we_n_o(s_we_n), .sram_lb_n_o(s_lb_n), .sram_ub_n_o(s_ub_n),
    .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_doe), .sram_dq_i(s_dq_i)
  );

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input int r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h at %0t", r, what, act, exp, $time);
    end
  endtask

  // ---- behavioural memory on the pins ----
  logic [15:0] sram_mem [int];
  logic [15:0] ref_mem  [int];
  function automatic logic [15:0] rd_sram(input int a);
    return sram_mem.exists(a) ? sram_mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] rd_ref(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  bit          wr_open = 0;
  int          wr_a;
  logic [15:0] wr_d;
  logic [1:0]  wr_l;
  always @(posedge clk) begin
    if (!s_cs_n && !s_we_n) begin
      wr_open = 1; wr_a = int'(s_addr);
      wr_d = s_doe ? s_dq_o : 16'h5A5A;
      wr_l = {~s_ub_n, ~s_lb_n};
    end else if (wr_open) begin
      logic [15:0] m;
      m = rd_sram(wr_a);
      if (wr_l[0]) m[7:0]  = wr_d[7:0];
      if (wr_l[1]) m[15:8] = wr_d[15:8];
      sram_mem[wr_a] = m;
      wr_open = 0;
    end
  end
  // Memory output: undriven lanes read as 8'h5A.
  always @(negedge clk) begin
    if (!s_cs_n && !s_oe_n && s_we_n) begin
      logic [15:0] m;
      m = rd_sram(int'(s_addr));
      s_dq_i = {s_ub_n ? 8'h5A : m[15:8], s_lb_n ? 8'h5A : m[7:0]};
    end else s_dq_i = 16'h5A5A;
  end

  // ---- cycle-by-cycle expected pins ----
  // kind: 1 idle (R1), 3 read phase (R3), 5 write phase (R5), 6 release (R6)
  typedef struct packed {
    logic [3:0]  kind;
    logic        cs_n, oe_n, we_n, lb_n, ub_n, doe, rv;
    logic [17:0] addr;
    logic [15:0] wd, rd;
  } exp_t;
  exp_t q[$];

  function automatic exp_t mk(input logic [3:0] k, input logic cs, oe, we, lb, ub, de, rv,
                              input logic [17:0] a, input logic [15:0] w, r);
    exp_t e;
    e.kind = k; e.cs_n = cs; e.oe_n = oe; e.we_n = we; e.lb_n = lb; e.ub_n = ub;
    e.doe = de; e.rv = rv; e.addr = a; e.wd = w; e.rd = r;
    return e;
  endfunction

  int cyc_cnt = 0;
  bit wd_fired = 0;
  always @(negedge clk) begin
    if (!rst && !wd_fired) begin
      exp_t e;
      cyc_cnt++;
      e = (q.size() != 0) ? q.pop_front() : mk(4'd1, 1,1,1,1,1,0,0, '0, '0, '0);
      // R8: ready only while idle
      chk(req_ready == (e.kind == 4'd1), 8, "ready", 32'(req_ready), 32'(e.kind == 4'd1));
      chk({s_cs_n, s_oe_n, s_we_n} == {e.cs_n, e.oe_n, e.we_n}, int'(e.kind), "cs/oe/we",
          32'({s_cs_n, s_oe_n, s_we_n}), 32'({e.cs_n, e.oe_n, e.we_n}));
      chk({s_ub_n, s_lb_n} == {e.ub_n, e.lb_n}, 4, "lanes",
          32'({s_ub_n, s_lb_n}), 32'({e.ub_n, e.lb_n}));
      chk(s_doe == e.doe, 6, "drive", 32'(s_doe), 32'(e.doe));
      if (!e.cs_n) chk(s_addr == e.addr, 8, "addr", 32'(s_addr), 32'(e.addr));
      if (e.doe)   chk(s_dq_o == e.wd, 5, "wdata", 32'(s_dq_o), 32'(e.wd));
      chk(rsp_valid == e.rv, 7, "rsp_valid", 32'(rsp_valid), 32'(e.rv));
      if (e.rv)    chk(rsp_rdata == e.rd, 7, "rdata", 32'(rsp_rdata), 32'(e.rd));
      // A request seen now with ready high is taken at the next edge.
      if (req_valid && req_ready) begin
        logic [15:0] exp_r, m;
        m = rd_ref(int'(req_addr));
        exp_r = {req_be[1] ? m[15:8] : 8'h00, req_be[0] ? m[7:0] : 8'h00};
        for (int i = 0; i < (req_write ? N_WR : N_RD); i++)
          q.push_back(req_write
            ? mk(4'd5, 0,1,0, ~req_be[0], ~req_be[1], 1, 0, req_addr, req_wdata, '0)
            : mk(4'd3, 0,0,1, ~req_be[0], ~req_be[1], 0, 0, req_addr, '0, '0));
        for (int i = 0; i < N_TA; i++)
          q.push_back(mk(4'd6, 1,1,1,1,1,0, (!req_write && i == 0), '0, '0, exp_r));
        if (req_write) begin
          if (req_be[0]) m[7:0]  = req_wdata[7:0];
          if (req_be[1]) m[15:8] = req_wdata[15:8];
          ref_mem[int'(req_addr)] = m;
        end
      end
      if (cyc_cnt > 20000) begin
        wd_fired = 1;
        chk(0, 0, "watchdog", 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic req(input logic w, input logic [17:0] a, input logic [1:0] be,
                     input logic [15:0] d);
    @(posedge clk); #2;
    req_valid = 1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 0;
  endtask

  task automatic settle();
    repeat (N_RD + N_WR + N_TA + 4) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(s_cs_n && s_oe_n && s_we_n && s_lb_n && s_ub_n && !s_doe && req_ready, 1, "reset pins",
        32'({s_cs_n, s_oe_n, s_we_n, s_lb_n, s_ub_n, s_doe, req_ready}), 32'h7D);
    // R2/R3/R5: full-word write then read back
    req(1, 18'h00010, 2'b11, 16'h1234); settle();
    req(0, 18'h00010, 2'b11, 16'h0000); settle();
    // R4: lane-wise writes merge, lane-wise reads mask
    req(1, 18'h00010, 2'b01, 16'hAAEE); settle();
    req(0, 18'h00010, 2'b11, 16'h0000); settle();
    req(1, 18'h00010, 2'b10, 16'h77FF); settle();
    req(0, 18'h00010, 2'b01, 16'h0000); settle();
    req(0, 18'h00010, 2'b10, 16'h0000); settle();
    req(0, 18'h00010, 2'b00, 16'h0000); settle();
    // Top address, unwritten address
    req(1, 18'h3FFFF, 2'b11, 16'hBEEF); settle();
    req(0, 18'h3FFFF, 2'b11, 16'h0000); settle();
    req(0, 18'h00020, 2'b11, 16'h0000); settle();
    // R6/R7: back-to-back write then read, request held across the release phase
    req(1, 18'h00044, 2'b11, 16'hC3C3);
    req(0, 18'h00044, 2'b11, 16'h0000); settle();
    // R8: requests offered while busy are dropped
    req(0, 18'h00010, 2'b11, 16'h0000);
    #2 req_valid = 1; req_write = 1; req_addr = 18'h00010; req_be = 2'b11; req_wdata = 16'hDEAD;
    @(posedge clk); #2 req_valid = 0;
    settle();
    req(0, 18'h00010, 2'b11, 16'h0000); settle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule